// File: doc/BRIEF.md
# Delay-Line Oscillation Self-Test

This block measures the speed of one delay line that has been switched into self-oscillation. A start pulse arms the test. From then on a core-clock counter advances on every core cycle. A second counter tallies the rising edges of the oscillator, which arrive through a synchronizer. When the programmed number of oscillator edges has been seen, both counters stop. The core-cycle total is held as the result and a sticky done flag rises.

The three limits are the terminal edge count, the expected core count and the allowed variation. All three are captured when the start pulse arrives, so software may rewrite them while a test runs. Once done is set, pass reports whether the measured count lies within the variation window around the expected count. The analog delay line and any register access lie outside the block. No data stream crosses the block's edge, so every pin is a plain control or status signal and no valid/ready handshake exists.

Top module: `dll_osc_bist`

## Requirements
- R1: After reset, result_o is 0, done_o is 0 and pass_o is 0.
- R2: A start pulse (start_i high for one cycle) clears the result to 0 and clears done_o on the next cycle. It also captures tcount_i, expect_i and cvar_i. Changes to those three inputs after the start cycle have no effect on the running test or on its verdict.
- R3: osc_i goes through a two-flop synchronizer. A rising edge of osc_i that is set up before core edge k is counted at core edge k+2. While the test runs, the result rises by exactly 1 on every core edge after the start edge, up to and including the edge at which the terminal oscillator edge is counted.
- R4: The test finishes on the N-th counted rising edge, where N is the captured terminal count for values 1 to 255. A terminal count of 0 means 256 edges.
- R5: done_o goes high on the cycle after the terminal edge is counted. It then stays high, and result_o stays unchanged, until the next start pulse.
- R6: pass_o is high only while done_o is high, the result is not saturated, and |result_o - expected| <= variation limit (unsigned 16-bit operands). pass_o is 0 whenever done_o is 0.
- R7: The core-cycle count saturates at 0xFFFF instead of wrapping. A saturated result forces pass_o to 0.
- R8: A start pulse during a running test restarts the measurement from zero with the newly captured limits.
- R9: Rising edges of osc_i while no test is running (after reset, or after done) change neither result_o nor done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that clears the counters and begins a test |
| osc_i | input | 1 | Delay-line oscillator output (asynchronous to clk) |
| tcount_i | input | 8 | Terminal oscillator edge count; 0 means 256 |
| cvar_i | input | 16 | Allowed variation of the core count |
| expect_i | input | 16 | Expected core count |
| result_o | output | 16 | Measured core-cycle count |
| done_o | output | 1 | Sticky test-finished flag |
| pass_o | output | 1 | Result within the variation window (valid while done_o is high) |

## Verification
The assertions check several rules on every cycle. The count steps by exactly one per core cycle while a test runs, and it holds once saturated. A start pulse clears the result and done. Done and the result hold until the next start. Pass never appears without done and never appears with a saturated count. Only the bench scenarios can show the rest: the exact synchronizer latency, the mapping of a terminal count of 0 to 256 edges, the captured limits being immune to later input changes, and a restart in mid-run. They also show the pass verdict at the window edges and oscillator edges being ignored outside a test. The bench checks these against a count it derives from the oscillator period it drives.

// File: rtl/dllbist_pkg.sv
package dllbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } bist_state_e;

  localparam int unsigned DEF_TCOUNT = 32'h0F;
  localparam int unsigned DEF_CVAR   = 32'h000F;

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // shift chain: stage 0 takes the asynchronous input
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= osc_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/bist_counters.sv
module bist_counters #(
  parameter int unsigned CW = 16,
  parameter int unsigned EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          rise_i,
  input  logic [EW-1:0] tcount_i,
  output logic [CW-1:0] core_o,
  output logic          sat_o,
  output logic          term_o
);

  logic [CW-1:0] core_q;
  logic [EW-1:0] edge_q;
  logic [EW-1:0] edge_nx;
  logic [CW-1:0] core_nx;

  assign edge_nx = edge_q + EW'(1);
  assign sat_o   = &core_q;
  assign core_nx = sat_o ? core_q : core_q + CW'(1);
  // a zero limit matches after the counter wraps through all 2^EW values
  assign term_o  = run_i & rise_i & (edge_nx == tcount_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      edge_q <= '0;
    end else if (clear_i) begin
      core_q <= '0;
      edge_q <= '0;
    end else if (run_i) begin
      core_q <= core_nx;
      if (rise_i) edge_q <= edge_nx;
    end
  end

  assign core_o = core_q;

endmodule

// File: rtl/bist_judge.sv
module bist_judge #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] result_i,
  input  logic [CW-1:0] expect_i,
  input  logic [CW-1:0] cvar_i,
  input  logic          done_i,
  input  logic          sat_i,
  output logic          pass_o
);

  logic [CW:0] diff;

  always_comb begin
    if (result_i >= expect_i) diff = {1'b0, result_i} - {1'b0, expect_i};
    else                      diff = {1'b0, expect_i} - {1'b0, result_i};
  end

  assign pass_o = done_i & ~sat_i & (diff <= {1'b0, cvar_i});

endmodule

// File: rtl/dll_osc_bist.sv
module dll_osc_bist
  import dllbist_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned EW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          osc_i,
  input  logic [7:0]    tcount_i,
  input  logic [15:0]   cvar_i,
  input  logic [15:0]   expect_i,
  output logic [15:0]   result_o,
  output logic          done_o,
  output logic          pass_o
);

  bist_state_e   st_q;
  logic [EW-1:0] tc_q;
  logic [CW-1:0] exp_q;
  logic [CW-1:0] cvar_q;
  logic          rise;
  logic          running;
  logic          term;
  logic          sat;
  logic [CW-1:0] core;

  assign running = (st_q == ST_RUN);

  // limits are captured at start so software can rewrite them mid-test
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= EW'(DEF_TCOUNT);
      exp_q  <= '0;
      cvar_q <= CW'(DEF_CVAR);
    end else if (start_i) begin
      tc_q   <= EW'(tcount_i);
      exp_q  <= CW'(expect_i);
      cvar_q <= CW'(cvar_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (start_i) begin
      st_q <= ST_RUN;
    end else begin
      case (st_q)
        ST_RUN:  if (term) st_q <= ST_FIN;
        ST_FIN:  st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  osc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_i  (osc_i),
    .rise_o (rise)
  );

  bist_counters #(.CW(CW), .EW(EW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .run_i    (running),
    .rise_i   (rise),
    .tcount_i (tc_q),
    .core_o   (core),
    .sat_o    (sat),
    .term_o   (term)
  );

  bist_judge #(.CW(CW)) i_judge (
    .result_i (core),
    .expect_i (exp_q),
    .cvar_i   (cvar_q),
    .done_i   (st_q == ST_FIN),
    .sat_i    (sat),
    .pass_o   (pass_o)
  );

  assign result_o = 16'(core);
  assign done_o   = (st_q == ST_FIN);

endmodule

// File: rtl/dll_osc_bist_chk.sv
module dll_osc_bist_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        running_i,
  input logic [15:0] result_o,
  input logic        done_o,
  input logic        pass_o
);

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (result_o == 16'd0 && !done_o));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && !start_i && result_o != 16'hFFFF) |=> result_o == $past(result_o) + 16'd1);

  assert_sticky_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(result_o)));

  assert_pass_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running_i && !start_i && result_o == 16'hFFFF) |=> result_o == 16'hFFFF);

  assert_sat_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_o == 16'hFFFF) |-> !pass_o);

endmodule

bind dll_osc_bist dll_osc_bist_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .running_i (running),
  .result_o  (result_o),
  .done_o    (done_o),
  .pass_o    (pass_o)
);

// File: tb/test_dll_osc_bist.sv
`timescale 1ns/1ps
module test_dll_osc_bist;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        osc_i = 1'b0;
  logic [7:0]  tcount_i = 8'd0;
  logic [15:0] cvar_i = 16'd0;
  logic [15:0] expect_i = 16'd0;
  logic [15:0] result_o;
  logic        done_o;
  logic        pass_o;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  dll_osc_bist i_dll_osc_bist (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .osc_i(osc_i),
    .tcount_i(tcount_i), .cvar_i(cvar_i), .expect_i(expect_i),
    .result_o(result_o), .done_o(done_o), .pass_o(pass_o)
  );

  typedef struct packed {
    logic [7:0]  tc;
    logic [7:0]  half;
    logic [15:0] expv;
    logic [15:0] cvar;
    logic        pass;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd15, 8'd2,  16'd59,  16'd0,      1'b1},
    '{8'd15, 8'd2,  16'd70,  16'd11,     1'b1},
    '{8'd15, 8'd2,  16'd70,  16'd10,     1'b0},
    '{8'd1,  8'd3,  16'd0,   16'd3,      1'b1},
    '{8'd8,  8'd5,  16'd80,  16'd6,      1'b0},
    '{8'd0,  8'd1,  16'd500, 16'd13,     1'b1},
    '{8'd3,  8'd4,  16'd19,  16'hFFFF,   1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start a test, scramble the limit inputs, then drive nr oscillator periods
  task automatic run_vec(input logic [7:0] tc, input int half, input logic [15:0] expv,
                         input logic [15:0] cv, input int nr);
    @(negedge clk);
    start_i = 1'b1; tcount_i = tc; expect_i = expv; cvar_i = cv;
    @(negedge clk);
    start_i = 1'b0;
    tcount_i = tc ^ 8'h5A; expect_i = ~expv; cvar_i = 16'd0;
    for (int i = 0; i < nr; i++) begin
      osc_i = 1'b1;
      repeat (half) @(negedge clk);
      osc_i = 1'b0;
      repeat (half) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] model(input logic [7:0] tc, input int half);
    int n = (tc == 8'd0) ? 256 : int'(tc);
    return 16'(3 + (n - 1) * 2 * half);
  endfunction

  initial begin
    repeat (185000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R1 result", 32'(result_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 pass", 32'(pass_o), 0);
    rst_n = 1'b1;

    // R9: oscillator edges before any start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); osc_i = 1'b1;
      repeat (2) @(negedge clk); osc_i = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R9 idle result", 32'(result_o), 0);
    check("R9 idle done", 32'(done_o), 0);

    // table walk: R2 R4 R6 (limits scrambled after start)
    for (int v = 0; v < NV; v++) begin
      run_vec(VECS[v].tc, int'(VECS[v].half), VECS[v].expv, VECS[v].cvar, (VECS[v].tc == 0) ? 256 : int'(VECS[v].tc));
      check("R4 R2 result", 32'(result_o), 32'(model(VECS[v].tc, int'(VECS[v].half))));
      check("R5 done", 32'(done_o), 1);
      check("R6 pass", 32'(pass_o), 32'(VECS[v].pass));
    end

    // R9 and R5: edges after done are ignored
    held = result_o;
    for (int i = 0; i < 3; i++) begin
      osc_i = 1'b1; repeat (2) @(negedge clk);
      osc_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R9 done result", 32'(result_o), 32'(held));
    check("R5 held done", 32'(done_o), 1);

    // R3: exact synchronizer latency, one edge terminates
    @(negedge clk);
    start_i = 1'b1; tcount_i = 8'd1; expect_i = 16'd3; cvar_i = 16'd0;
    @(negedge clk);
    check("R2 done cleared", 32'(done_o), 0);
    check("R2 result cleared", 32'(result_o), 0);
    start_i = 1'b0; osc_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 not yet done", 32'(done_o), 0);
    @(negedge clk);
    check("R3 done edge", 32'(done_o), 1);
    check("R3 latency result", 32'(result_o), 3);
    check("R6 exact pass", 32'(pass_o), 1);
    osc_i = 1'b0;
    repeat (4) @(negedge clk);

    // R8: restart in mid-run
    run_vec(8'd5, 2, 16'd19, 16'd0, 2);
    check("R8 partial not done", 32'(done_o), 0);
    run_vec(8'd5, 2, 16'd19, 16'd0, 5);
    check("R8 restart result", 32'(result_o), 19);
    check("R8 restart pass", 32'(pass_o), 1);

    // R7: saturation
    run_vec(8'd2, 1, 16'hFFFF, 16'hFFFF, 1);
    repeat (65600) @(negedge clk);
    check("R7 saturated value", 32'(result_o), 32'hFFFF);
    check("R7 still running", 32'(done_o), 0);
    osc_i = 1'b1; @(negedge clk); osc_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 done", 32'(done_o), 1);
    check("R7 held value", 32'(result_o), 32'hFFFF);
    check("R7 forced fail", 32'(pass_o), 0);

    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule